// File: doc/BRIEF.md
# Flash Self-Programming Controller

This unit sits beside the CPU core of a small 8-bit controller and governs how software modifies its own program flash. Software writes a six-bit command into a control register. A legal command opens a short timed window. Inside that window, a store-program strobe from the instruction decoder performs the armed action. That action is one of the following: filling one word of a temporary page buffer, clearing the whole buffer, or launching a page erase or a page write on the flash array. A fuse/lock read command instead lets a load-program strobe return the fuse low byte, the fuse high byte or the lock byte in place of flash data.

Commands that are not consumed in time disarm themselves. A command that starts an erase or a write stays in the register until the flash array reports completion, and no new command is taken meanwhile. A pending EEPROM write suppresses command writes, store-program actions and fuse/lock reads. The flash array, the fuse storage and the decoder are outside the unit and are reached through plain ports. The flash writer fetches the buffered words through a synchronous read port.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset, `cmd_state` is 0, `flash_req` and `flash_busy` are 0, `ld_data` is 0, and every page buffer word reads 0xFFFF.
- R2: A write to the command register takes effect only for the patterns 000001 (fill), 000011 (erase), 000101 (write), 001001 (fuse/lock read), 010001 (clear buffer) and 100001 (signature). Any other pattern leaves `cmd_state` unchanged.
- R3: A store-program strobe is honoured on any of the four clock edges after the command write. If none arrives, `cmd_state` returns to 0 at the fourth edge, and a later strobe has no effect.
- R4: In fill mode, a store strobe writes `st_wdata` into buffer word `ptr[6:1]` (pointer bit 0 ignored) and clears `cmd_state`. `pbuf_rdata` shows the word one cycle after `pbuf_raddr` is applied.
- R5: In erase or write mode, a store strobe raises `flash_req` for one cycle and sets `flash_busy`. `flash_op` is 0 for erase and 1 for write, and `flash_page` is `ptr[15:7]`. `cmd_state` holds its value until the cycle after `flash_done`, when both `cmd_state` and `flash_busy` go to 0.
- R6: While `flash_busy` is 1, command writes are ignored.
- R7: In fuse/lock read mode, a load strobe on one of the three edges after the command write loads `ld_data` as follows: pointer 0x0000 gives the fuse low byte, 0x0003 gives the fuse high byte, and 0x0001 gives {6'b111111, lock_bits}. Any other pointer gives 0xFF.
- R8: The fuse/lock read mode clears after one read, or at the third edge if no load strobe arrives. Any load strobe outside that mode loads `flash_rdata` into `ld_data`.
- R9: While `ee_busy` is 1, command writes are ignored. Store strobes then change nothing, and load strobes return `flash_rdata` while an armed command stays armed.
- R10: In clear-buffer mode, a store strobe makes every buffer word read 0xFFFF and clears `cmd_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 6 | Command pattern to write |
| cmd_state | output | 6 | Current command register contents |
| st_strobe | input | 1 | Store-program execute strobe |
| ld_strobe | input | 1 | Load-program execute strobe |
| ptr | input | 16 | Address pointer |
| st_wdata | input | 16 | Data word for a buffer fill |
| ee_busy | input | 1 | EEPROM write in progress |
| flash_req | output | 1 | One-cycle start request to the flash array |
| flash_op | output | 1 | 0 erase, 1 write |
| flash_page | output | 9 | Page number for the request |
| flash_done | input | 1 | Flash operation finished |
| flash_busy | output | 1 | Flash erase or write in progress |
| flash_rdata | input | 8 | Flash byte at the pointer |
| fuse_lo | input | 8 | Fuse low byte |
| fuse_hi | input | 8 | Fuse high byte |
| lock_bits | input | 2 | Lock bits 2 and 1 |
| ld_data | output | 8 | Load-program result |
| pbuf_raddr | input | 6 | Page buffer read index for the flash writer |
| pbuf_rdata | output | 16 | Page buffer read data |

## Verification
The hardest situations to reach are the exact window edges. A strobe must land on the last accepted edge and also on the first rejected one, for both the four-cycle store window and the three-cycle read window. The directed tasks count negative edges from the command write and place a single-cycle strobe on a chosen edge. Another hard case is an EEPROM busy period that begins after a command is already armed. The bench raises the busy input between the command write and the strobe, then shows that the command survives and still expires.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

  localparam int BYTE_W = 8;
  localparam int CMD_W  = 6;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE  = 6'b000000,
    CMD_FILL  = 6'b000001,
    CMD_ERASE = 6'b000011,
    CMD_WRITE = 6'b000101,
    CMD_FUSE  = 6'b001001,
    CMD_CLEAR = 6'b010001,
    CMD_SIG   = 6'b100001
  } cmd_e;

  function automatic logic cmd_legal(input logic [CMD_W-1:0] v);
    case (v)
      CMD_FILL, CMD_ERASE, CMD_WRITE, CMD_FUSE, CMD_CLEAR, CMD_SIG: cmd_legal = 1'b1;
      default: cmd_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/selfprog_seq.sv
module selfprog_seq
  import selfprog_pkg::*;
#(
  parameter int STORE_WIN = 4,
  parameter int LOAD_WIN  = 3,
  parameter int PAGE_W    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              ee_busy,
  input  logic              st_strobe,
  input  logic              ld_strobe,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              flash_done,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              flash_req,
  output logic              flash_op,
  output logic [PAGE_W-1:0] flash_page,
  output logic              busy,
  output logic              fill_we,
  output logic              clr_all,
  output logic              fuse_take
);

  localparam int SW = $clog2(STORE_WIN + 1);
  localparam int LW = $clog2(LOAD_WIN + 1);

  logic [SW-1:0] st_cnt;
  logic [LW-1:0] ld_cnt;
  logic          wr_ok;
  logic          st_take;

  assign wr_ok     = cmd_we && !ee_busy && !busy && cmd_legal(cmd_wdata);
  assign st_take   = !busy && !wr_ok && st_strobe && !ee_busy && (st_cnt != '0);
  assign fuse_take = !busy && !wr_ok && ld_strobe && !ee_busy && (ld_cnt != '0)
                     && (cmd_q == CMD_FUSE);
  assign fill_we   = st_take && (cmd_q == CMD_FILL);
  assign clr_all   = st_take && (cmd_q == CMD_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= '0;
      st_cnt     <= '0;
      ld_cnt     <= '0;
      busy       <= 1'b0;
      flash_req  <= 1'b0;
      flash_op   <= 1'b0;
      flash_page <= '0;
    end else begin
      flash_req <= 1'b0;
      if (busy) begin
        if (flash_done) begin
          busy  <= 1'b0;
          cmd_q <= '0;
        end
      end else if (wr_ok) begin
        cmd_q  <= cmd_wdata;
        st_cnt <= SW'(STORE_WIN);
        ld_cnt <= LW'(LOAD_WIN);
      end else if (st_take) begin
        st_cnt <= '0;
        ld_cnt <= '0;
        if (cmd_q == CMD_ERASE || cmd_q == CMD_WRITE) begin
          busy       <= 1'b1;
          flash_req  <= 1'b1;
          flash_op   <= (cmd_q == CMD_WRITE);
          flash_page <= page_in;
        end else begin
          cmd_q <= '0;
        end
      end else if (fuse_take) begin
        cmd_q  <= '0;
        st_cnt <= '0;
        ld_cnt <= '0;
      end else begin
        if (st_cnt != '0) st_cnt <= st_cnt - 1'b1;
        if (ld_cnt != '0) ld_cnt <= ld_cnt - 1'b1;
        if (st_cnt == SW'(1) ||
            (cmd_q == CMD_FUSE && ld_cnt == LW'(1))) begin
          cmd_q  <= '0;
          st_cnt <= '0;
          ld_cnt <= '0;
        end
      end
    end
  end

  // R2: the register never holds an unlisted pattern
  p_cmd_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == '0) || cmd_legal(cmd_q));

  // R3: an armed idle command always has store window left
  p_armed_window_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != '0 && !busy) |-> (st_cnt != '0));

  // R5: enable bit held for the whole flash operation
  p_en_held_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> cmd_q[0]);

  // R5: request only accompanies a busy operation
  p_req_busy_r5: assert property (@(posedge clk) disable iff (rst)
    flash_req |-> busy);

  // R7: fuse mode never outlives its read window
  p_fuse_window_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_FUSE) |-> (ld_cnt != '0));

  // R9: nothing arms while the EEPROM is busy
  p_ee_no_arm_r9: assert property (@(posedge clk) disable iff (rst)
    (ee_busy && cmd_q == '0 && !busy) |=> (cmd_q == '0));

endmodule

// File: rtl/selfprog_pagebuf.sv
module selfprog_pagebuf #(
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 64,
  parameter int IDX_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0]     mem [PAGE_WORDS];
  logic [PAGE_WORDS-1:0] valid;
  logic [DATA_W-1:0]     mem_q;
  logic                  vld_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    mem_q <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      vld_q <= 1'b0;
    end else begin
      if (clr)     valid       <= '0;
      else if (we) valid[widx] <= 1'b1;
      vld_q <= valid[ridx];
    end
  end

  assign rdata = vld_q ? mem_q : {DATA_W{1'b1}};

  // R10: a clear empties every entry
  p_clear_all_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (valid == '0));

  // R4: a fill marks its entry
  p_fill_marks_r4: assert property (@(posedge clk) disable iff (rst)
    (we && !clr) |=> valid[$past(widx)]);

endmodule

// File: rtl/selfprog_rdsel.sv
module selfprog_rdsel
  import selfprog_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_strobe,
  input  logic              fuse_take,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [BYTE_W-1:0] flash_rdata,
  input  logic [BYTE_W-1:0] fuse_lo,
  input  logic [BYTE_W-1:0] fuse_hi,
  input  logic [1:0]        lock_bits,
  output logic [BYTE_W-1:0] ld_data
);

  logic [BYTE_W-1:0] cfg_byte;

  always_comb begin
    if (ptr == ADDR_W'(0))      cfg_byte = fuse_lo;
    else if (ptr == ADDR_W'(1)) cfg_byte = {{(BYTE_W-2){1'b1}}, lock_bits};
    else if (ptr == ADDR_W'(3)) cfg_byte = fuse_hi;
    else                        cfg_byte = {BYTE_W{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (rst)            ld_data <= '0;
    else if (ld_strobe) ld_data <= fuse_take ? cfg_byte : flash_rdata;
  end

  // R8: a plain load returns the flash byte
  p_plain_load_r8: assert property (@(posedge clk) disable iff (rst)
    (ld_strobe && !fuse_take) |=> (ld_data == $past(flash_rdata)));

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
  import selfprog_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 64,
  parameter int STORE_WIN  = 4,
  parameter int LOAD_WIN   = 3
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    cmd_we,
  input  logic [5:0]                              cmd_wdata,
  output logic [5:0]                              cmd_state,
  input  logic                                    st_strobe,
  input  logic                                    ld_strobe,
  input  logic [ADDR_W-1:0]                       ptr,
  input  logic [DATA_W-1:0]                       st_wdata,
  input  logic                                    ee_busy,
  output logic                                    flash_req,
  output logic                                    flash_op,
  output logic [ADDR_W-$clog2(PAGE_WORDS)-2:0]    flash_page,
  input  logic                                    flash_done,
  output logic                                    flash_busy,
  input  logic [7:0]                              flash_rdata,
  input  logic [7:0]                              fuse_lo,
  input  logic [7:0]                              fuse_hi,
  input  logic [1:0]                              lock_bits,
  output logic [7:0]                              ld_data,
  input  logic [$clog2(PAGE_WORDS)-1:0]           pbuf_raddr,
  output logic [DATA_W-1:0]                       pbuf_rdata
);

  localparam int IDX_W  = $clog2(PAGE_WORDS);
  localparam int OFF_W  = IDX_W + 1;
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic fill_we;
  logic clr_all;
  logic fuse_take;

  selfprog_seq #(
    .STORE_WIN (STORE_WIN),
    .LOAD_WIN  (LOAD_WIN),
    .PAGE_W    (PAGE_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_we     (cmd_we),
    .cmd_wdata  (cmd_wdata),
    .ee_busy    (ee_busy),
    .st_strobe  (st_strobe),
    .ld_strobe  (ld_strobe),
    .page_in    (ptr[ADDR_W-1:OFF_W]),
    .flash_done (flash_done),
    .cmd_q      (cmd_state),
    .flash_req  (flash_req),
    .flash_op   (flash_op),
    .flash_page (flash_page),
    .busy       (flash_busy),
    .fill_we    (fill_we),
    .clr_all    (clr_all),
    .fuse_take  (fuse_take)
  );

  selfprog_pagebuf #(
    .DATA_W     (DATA_W),
    .PAGE_WORDS (PAGE_WORDS),
    .IDX_W      (IDX_W)
  ) u_pbuf (
    .clk   (clk),
    .rst   (rst),
    .we    (fill_we),
    .widx  (ptr[IDX_W:1]),
    .wdata (st_wdata),
    .clr   (clr_all),
    .ridx  (pbuf_raddr),
    .rdata (pbuf_rdata)
  );

  selfprog_rdsel #(
    .ADDR_W (ADDR_W)
  ) u_rdsel (
    .clk         (clk),
    .rst         (rst),
    .ld_strobe   (ld_strobe),
    .fuse_take   (fuse_take),
    .ptr         (ptr),
    .flash_rdata (flash_rdata),
    .fuse_lo     (fuse_lo),
    .fuse_hi     (fuse_hi),
    .lock_bits   (lock_bits),
    .ld_data     (ld_data)
  );

  // R6: a busy operation keeps its command against any write
  p_busy_locks_r6: assert property (@(posedge clk) disable iff (rst)
    (flash_busy && !flash_done) |=> $stable(cmd_state));

endmodule

// File: tb/selfprog_ctrl_tb.sv
module selfprog_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [5:0]  cmd_wdata = '0;
  logic [5:0]  cmd_state;
  logic        st_strobe = 1'b0;
  logic        ld_strobe = 1'b0;
  logic [15:0] ptr = '0;
  logic [15:0] st_wdata = '0;
  logic        ee_busy = 1'b0;
  logic        flash_req;
  logic        flash_op;
  logic [8:0]  flash_page;
  logic        flash_done = 1'b0;
  logic        flash_busy;
  logic [7:0]  flash_rdata = 8'h5A;
  logic [7:0]  fuse_lo = 8'hA1;
  logic [7:0]  fuse_hi = 8'hC3;
  logic [1:0]  lock_bits = 2'b10;
  logic [7:0]  ld_data;
  logic [5:0]  pbuf_raddr = '0;
  logic [15:0] pbuf_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  selfprog_ctrl u_dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_state(cmd_state), .st_strobe(st_strobe), .ld_strobe(ld_strobe),
    .ptr(ptr), .st_wdata(st_wdata), .ee_busy(ee_busy),
    .flash_req(flash_req), .flash_op(flash_op), .flash_page(flash_page),
    .flash_done(flash_done), .flash_busy(flash_busy),
    .flash_rdata(flash_rdata), .fuse_lo(fuse_lo), .fuse_hi(fuse_hi),
    .lock_bits(lock_bits), .ld_data(ld_data),
    .pbuf_raddr(pbuf_raddr), .pbuf_rdata(pbuf_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmd(input logic [5:0] v);
    cmd_wdata = v; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic st_pulse();
    st_strobe = 1'b1;
    @(negedge clk);
    st_strobe = 1'b0;
  endtask

  task automatic ld_pulse();
    ld_strobe = 1'b1;
    @(negedge clk);
    ld_strobe = 1'b0;
  endtask

  task automatic rd_buf(input logic [5:0] idx, output logic [15:0] v);
    pbuf_raddr = idx;
    @(negedge clk);
    v = pbuf_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 cmd_state", 32'(cmd_state), 0);
    chk("R1 flash_busy", 32'(flash_busy), 0);
    chk("R1 flash_req", 32'(flash_req), 0);
    chk("R1 ld_data", 32'(ld_data), 0);
    rd_buf(6'd9, v);
    chk("R1 buffer empty", 32'(v), 32'hFFFF);
  endtask

  task automatic t_encodings();
    wr_cmd(6'b000111);
    chk("R2 illegal 000111", 32'(cmd_state), 0);
    wr_cmd(6'b100011);
    chk("R2 illegal 100011", 32'(cmd_state), 0);
    wr_cmd(6'b100001);
    chk("R2 legal signature", 32'(cmd_state), 32'h21);
    cyc(4);
    chk("R3 signature expired", 32'(cmd_state), 0);
  endtask

  task automatic t_fill_last_edge();
    logic [15:0] v;
    ptr = 16'h0013; st_wdata = 16'hBEEF;
    wr_cmd(6'b000001);
    cyc(3);
    st_pulse();
    chk("R4 fill clears cmd", 32'(cmd_state), 0);
    rd_buf(6'd9, v);
    chk("R4 fill word at ptr[6:1]", 32'(v), 32'hBEEF);
  endtask

  task automatic t_store_expiry();
    logic [15:0] v;
    ptr = 16'h0004; st_wdata = 16'h1234;
    wr_cmd(6'b000001);
    cyc(3);
    chk("R3 armed at third edge", 32'(cmd_state), 1);
    cyc(1);
    chk("R3 cleared at fourth edge", 32'(cmd_state), 0);
    st_pulse();
    rd_buf(6'd2, v);
    chk("R3 late strobe no write", 32'(v), 32'hFFFF);
  endtask

  task automatic t_erase();
    ptr = 16'h0380;
    wr_cmd(6'b000011);
    st_pulse();
    chk("R5 erase req", 32'(flash_req), 1);
    chk("R5 erase op", 32'(flash_op), 0);
    chk("R5 erase page", 32'(flash_page), 7);
    chk("R5 busy set", 32'(flash_busy), 1);
    cyc(1);
    chk("R5 req one cycle", 32'(flash_req), 0);
    wr_cmd(6'b000001);
    chk("R6 write ignored while busy", 32'(cmd_state), 32'h03);
    cyc(5);
    chk("R5 enable held", 32'(cmd_state), 32'h03);
    flash_done = 1'b1;
    @(negedge clk);
    flash_done = 1'b0;
    chk("R5 busy cleared on done", 32'(flash_busy), 0);
    chk("R5 cmd cleared on done", 32'(cmd_state), 0);
  endtask

  task automatic t_write();
    ptr = 16'h0100;
    wr_cmd(6'b000101);
    cyc(1);
    st_pulse();
    chk("R5 write op", 32'(flash_op), 1);
    chk("R5 write page", 32'(flash_page), 2);
    cyc(2);
    flash_done = 1'b1;
    @(negedge clk);
    flash_done = 1'b0;
    chk("R5 write done", 32'(flash_busy), 0);
  endtask

  task automatic t_fuse_reads();
    ptr = 16'h0001;
    wr_cmd(6'b001001);
    cyc(2);
    ld_pulse();
    chk("R7 lock byte on last edge", 32'(ld_data), 32'hFE);
    chk("R8 cleared after read", 32'(cmd_state), 0);
    ptr = 16'h0000;
    wr_cmd(6'b001001);
    ld_pulse();
    chk("R7 fuse low", 32'(ld_data), 32'hA1);
    ptr = 16'h0003;
    wr_cmd(6'b001001);
    ld_pulse();
    chk("R7 fuse high", 32'(ld_data), 32'hC3);
    ptr = 16'h0002;
    wr_cmd(6'b001001);
    ld_pulse();
    chk("R7 other pointer", 32'(ld_data), 32'hFF);
  endtask

  task automatic t_fuse_expiry();
    ptr = 16'h0000;
    wr_cmd(6'b001001);
    cyc(2);
    chk("R8 armed before third edge", 32'(cmd_state), 32'h09);
    cyc(1);
    chk("R8 cleared at third edge", 32'(cmd_state), 0);
    ld_pulse();
    chk("R8 late load gives flash", 32'(ld_data), 32'h5A);
    ptr = 16'h0003;
    ld_pulse();
    chk("R8 plain load", 32'(ld_data), 32'h5A);
  endtask

  task automatic t_eeprom();
    logic [15:0] v;
    ee_busy = 1'b1;
    wr_cmd(6'b000001);
    chk("R9 write ignored", 32'(cmd_state), 0);
    ee_busy = 1'b0;
    ptr = 16'h0001;
    wr_cmd(6'b001001);
    ee_busy = 1'b1;
    ld_pulse();
    chk("R9 fuse read blocked", 32'(ld_data), 32'h5A);
    chk("R9 command stays armed", 32'(cmd_state), 32'h09);
    ee_busy = 1'b0;
    cyc(3);
    ptr = 16'h000A; st_wdata = 16'h7777;
    wr_cmd(6'b000001);
    ee_busy = 1'b1;
    st_pulse();
    ee_busy = 1'b0;
    cyc(4);
    rd_buf(6'd5, v);
    chk("R9 store blocked", 32'(v), 32'hFFFF);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr_cmd(6'b010001);
    st_pulse();
    chk("R10 cmd cleared", 32'(cmd_state), 0);
    rd_buf(6'd9, v);
    chk("R10 buffer word erased", 32'(v), 32'hFFFF);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_encodings();
    t_fill_last_edge();
    t_store_expiry();
    t_erase();
    t_write();
    t_fuse_reads();
    t_fuse_expiry();
    t_eeprom();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule